// File: doc/BRIEF.md
# Two-Phase Select SPI Master Sequencer

This block is the master side of a shared SPI bus that reaches many slaves through only two select lines: an address select and a data select. Each slave board carries a small latch that is loaded while the address select is low. A zero at that slave's own bit position opens its gate for the next data-select frame. The block accepts a request made of a slave index and a data byte. When needed, it first shifts out an address frame. It then shifts out the data byte while capturing the slave's reply, and hands the reply back with a one-cycle done pulse.

The sequencer remembers which slave it last addressed. A request for that same slave goes straight to the data frame, which saves one full frame of bus time. After reset nothing is remembered, so the first request always addresses. The serial clock runs in SPI mode 0 and is derived from the system clock by a parameterised divider. Between the address frame and the data frame, both selects stay high for at least one full serial clock period.

Top module: `spi_twosel_master`

## Requirements
- R1: While reset is applied and on leaving it, both select outputs are high, sclk is low, busy is low and done is low.
- R2: The first request after reset always sends an address frame, even if it names the slave addressed before reset.
- R3: An address frame is N_SLAVES bits long with sel_addr_n low and sel_data_n high. It is sent MSB first. Every bit is one except bit k (weight 2^k), which is zero, where k is the requested slave index.
- R4: A request whose index equals the last addressed slave sends no address frame. sel_addr_n stays high and the data frame starts in the cycle after acceptance.
- R5: A request whose index differs from the last addressed slave sends a new address frame before the data frame.
- R6: The data frame is DATA_W bits long, sent MSB first with sel_data_n low and sel_addr_n high. The two selects are never low together.
- R7: MISO is sampled on each rising sclk edge, MSB first. rx_data holds the DATA_W sampled bits when done pulses.
- R8: sclk is low whenever both selects are high, each frame has exactly its bit count of rising edges, and mosi does not change while sclk is high.
- R9: Between an address frame and its data frame, both selects stay high for at least 2*HALF_DIV clock cycles.
- R10: busy rises in the cycle after a request is accepted and stays high until done. done is a one-cycle pulse, and requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_slave | input | $clog2(N_SLAVES) | Target slave index |
| req_data | input | DATA_W | Byte to send in the data frame |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | DATA_W | Byte captured from MISO |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from the selected slave |
| sel_addr_n | output | 1 | Address select, active low |
| sel_data_n | output | 1 | Data select, active low |

## Verification
The hardest situation to reach is the cached slave index becoming invalid again. This happens when a reset falls between two requests for the same slave, and the port-visible effect is only the presence or absence of an address frame. The bench addresses a slave, applies reset in the middle of the test, and then requests the same slave again, expecting a full address frame. It also sends a second request while busy with a different index and data, and checks that neither the cache nor the frames change.

// File: rtl/spi_twosel_pkg.sv
// Package: shared types and helpers for the two-select SPI master.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_twosel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_GAP  = 2'd2,
        ST_DATA = 2'd3
    } seq_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_twosel_clkgen.sv
// Module: serial clock generator. While en is high it toggles sclk every
// HALF_DIV system cycles, flagging the cycle of each toggle as a rise or
// fall tick. While en is low sclk is held low and the divider is cleared.
// Assumes: HALF_DIV >= 1.
module spi_twosel_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = en && (cnt == LAST);
    assign rise_tick = wrap && !sclk;
    assign fall_tick = wrap && sclk;

    // Divider counter and sclk toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sclk);

endmodule

// File: rtl/spi_twosel_shifter.sv
// Module: frame shift engine. On load it takes a left-aligned word and a
// bit count, presents the MSB on mosi, samples miso on each rise tick and
// shifts on each fall tick. After the last bit's falling edge it stops and
// pulses frame_done one cycle later.
// Assumes: load only arrives while not active.
module spi_twosel_shifter #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic [$clog2(FRAME_W+1)-1:0] load_bits,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               miso,
    output logic               active,
    output logic               mosi,
    output logic               frame_done,
    output logic [FRAME_W-1:0] rx_word
);
    localparam int BW = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sh;
    logic [BW-1:0]      bits_q;
    logic [BW-1:0]      bit_cnt;

    assign mosi = active & sh[FRAME_W-1];

    // Frame state: load, sample on rise, shift or finish on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= '0;
            bits_q     <= '0;
            bit_cnt    <= '0;
            active     <= 1'b0;
            frame_done <= 1'b0;
            rx_word    <= '0;
        end else begin
            frame_done <= 1'b0;
            if (load) begin
                sh      <= load_word;
                bits_q  <= load_bits;
                bit_cnt <= '0;
                rx_word <= '0;
                active  <= 1'b1;
            end else if (active && rise_tick) begin
                rx_word <= {rx_word[FRAME_W-2:0], miso};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (active && fall_tick) begin
                if (bit_cnt == bits_q) begin
                    active     <= 1'b0;
                    frame_done <= 1'b1;
                end else begin
                    sh <= {sh[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end

    a_r8_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bit_cnt <= bits_q));
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !active);

endmodule

// File: rtl/spi_twosel_ctrl.sv
// Module: transaction sequencer. Accepts requests while idle, decides from
// the cached slave index whether an address frame is needed, drives the two
// selects, inserts the inter-frame gap and returns the reply with done.
// Assumes: the shifter pulses frame_done once per load.
module spi_twosel_ctrl
    import spi_twosel_pkg::*;
#(
    parameter int N_SLAVES = 8,
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 2,
    parameter int FRAME_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [$clog2(N_SLAVES)-1:0] req_slave,
    input  logic [DATA_W-1:0]           req_data,
    input  logic                        frame_done,
    input  logic [FRAME_W-1:0]          rx_word,
    output logic                        load,
    output logic [FRAME_W-1:0]          load_word,
    output logic [$clog2(FRAME_W+1)-1:0] load_bits,
    output logic                        busy,
    output logic                        done,
    output logic [DATA_W-1:0]           rx_data,
    output logic                        sel_addr_n,
    output logic                        sel_data_n
);
    localparam int IW      = $clog2(N_SLAVES);
    localparam int BW      = $clog2(FRAME_W + 1);
    localparam int GAP_CYC = 2 * HALF_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);

    seq_state_t        state;
    logic [IW-1:0]     cache_idx;
    logic              cache_vld;
    logic [DATA_W-1:0] cur_data;
    logic [GW-1:0]     gap_cnt;
    logic              accept, hit, gap_end;
    logic [N_SLAVES-1:0] addr_pat;
    logic [FRAME_W-1:0]  addr_word, data_word;

    assign accept     = (state == ST_IDLE) && req_valid;
    assign hit        = cache_vld && (cache_idx == req_slave);
    assign gap_end    = (state == ST_GAP) && (gap_cnt == GW'(GAP_CYC - 1));
    assign busy       = (state != ST_IDLE);
    assign sel_addr_n = (state != ST_ADDR);
    assign sel_data_n = (state != ST_DATA);

    // Build the left-aligned address and data words for the shifter.
    always_comb begin
        addr_pat  = ~(N_SLAVES'(1) << req_slave);
        addr_word = '0;
        addr_word[FRAME_W-1 -: N_SLAVES] = addr_pat;
        data_word = '0;
        if (state == ST_GAP) data_word[FRAME_W-1 -: DATA_W] = cur_data;
        else                 data_word[FRAME_W-1 -: DATA_W] = req_data;
    end

    // Choose what the shifter loads and when.
    always_comb begin
        load      = 1'b0;
        load_word = data_word;
        load_bits = BW'(DATA_W);
        if (accept && !hit) begin
            load      = 1'b1;
            load_word = addr_word;
            load_bits = BW'(N_SLAVES);
        end else if (accept || gap_end) begin
            load = 1'b1;
        end
    end

    // Sequencer state, cache, gap timer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cache_idx <= '0;
            cache_vld <= 1'b0;
            cur_data  <= '0;
            gap_cnt   <= '0;
            done      <= 1'b0;
            rx_data   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    cur_data  <= req_data;
                    cache_idx <= req_slave;
                    cache_vld <= 1'b1;
                    state     <= hit ? ST_DATA : ST_ADDR;
                end
                ST_ADDR: if (frame_done) begin
                    gap_cnt <= '0;
                    state   <= ST_GAP;
                end
                ST_GAP: begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_end) state <= ST_DATA;
                end
                ST_DATA: if (frame_done) begin
                    rx_data <= rx_word[DATA_W-1:0];
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    a_r4_skip_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> (sel_addr_n && !sel_data_n));
    a_r9_gap_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_addr_n) |=> sel_data_n);

endmodule

// File: rtl/spi_twosel_master.sv
// Module: top of the two-select SPI master. Wires the sequencer, the frame
// shifter and the serial clock generator together.
// Assumes: N_SLAVES >= 2, DATA_W >= 2, HALF_DIV >= 1; SPI mode 0.
module spi_twosel_master
    import spi_twosel_pkg::*;
#(
    parameter int N_SLAVES = 8,
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [$clog2(N_SLAVES)-1:0] req_slave,
    input  logic [DATA_W-1:0]           req_data,
    output logic                        busy,
    output logic                        done,
    output logic [DATA_W-1:0]           rx_data,
    output logic                        sclk,
    output logic                        mosi,
    input  logic                        miso,
    output logic                        sel_addr_n,
    output logic                        sel_data_n
);
    localparam int FRAME_W = imax(N_SLAVES, DATA_W);
    localparam int BW      = $clog2(FRAME_W + 1);

    logic               load, active, frame_done, rise_tick, fall_tick;
    logic [FRAME_W-1:0] load_word, rx_word;
    logic [BW-1:0]      load_bits;

    spi_twosel_ctrl #(
        .N_SLAVES(N_SLAVES), .DATA_W(DATA_W),
        .HALF_DIV(HALF_DIV), .FRAME_W(FRAME_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_slave(req_slave), .req_data(req_data),
        .frame_done(frame_done), .rx_word(rx_word),
        .load(load), .load_word(load_word), .load_bits(load_bits),
        .busy(busy), .done(done), .rx_data(rx_data),
        .sel_addr_n(sel_addr_n), .sel_data_n(sel_data_n)
    );

    spi_twosel_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(load), .load_word(load_word), .load_bits(load_bits),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .miso(miso),
        .active(active), .mosi(mosi), .frame_done(frame_done),
        .rx_word(rx_word)
    );

    spi_twosel_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(active),
        .sclk(sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    a_r8_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    a_r8_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_addr_n && sel_data_n && !$past(active)) |-> !sclk);

endmodule

// File: tb/sim_spi_twosel_master.sv
// Bench: directed scenarios against a behavioural slave model.
module sim_spi_twosel_master;
    localparam int NS   = 8;
    localparam int DW   = 8;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_slave = '0;
    logic [DW-1:0] req_data = '0;
    logic busy, done, sclk, mosi, miso, sel_addr_n, sel_data_n;
    logic [DW-1:0] rx_data;

    int checks = 0, errors = 0, cyc = 0;

    always #2 clk = ~clk;

    spi_twosel_master #(.N_SLAVES(NS), .DATA_W(DW), .HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slave(req_slave),
        .req_data(req_data), .busy(busy), .done(done), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .miso(miso),
        .sel_addr_n(sel_addr_n), .sel_data_n(sel_data_n)
    );

    // Slave model: collects frames and returns a reply on miso.
    int a_frames = 0, d_frames = 0, a_bits = 0, d_bits = 0;
    logic [NS-1:0] a_val = '0;
    logic [DW-1:0] d_val = '0, s_reply = '0, s_tx = '0;
    assign miso = s_tx[DW-1];

    always @(negedge sel_addr_n) begin a_frames++; a_bits = 0; a_val = '0; end
    always @(negedge sel_data_n) begin d_frames++; d_bits = 0; d_val = '0; s_tx = s_reply; end
    always @(posedge sclk) begin
        if (!sel_addr_n) begin a_val = {a_val[NS-2:0], mosi}; a_bits++; end
        if (!sel_data_n) begin d_val = {d_val[DW-2:0], mosi}; d_bits++; end
    end
    always @(negedge sclk) if (!sel_data_n) s_tx = {s_tx[DW-2:0], 1'b0};

    // Protocol monitor sampled away from the active edge.
    int v_idle = 0, v_both = 0, v_gap = 0, v_done = 0, hi_run = 0;
    logic prev_done = 1'b0, last_addr = 1'b0, prev_hi = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sel_addr_n && sel_data_n && sclk) v_idle++;
            if (!sel_addr_n && !sel_data_n) v_both++;
            if (done && prev_done) v_done++;
            if (!sel_data_n && prev_hi && last_addr && hi_run < 2*HALF) v_gap++;
            if (!sel_addr_n) last_addr = 1'b1;
            else if (!sel_data_n) last_addr = 1'b0;
            hi_run  = (sel_addr_n && sel_data_n) ? hi_run + 1 : 0;
            prev_hi = sel_addr_n && sel_data_n;
            prev_done = done;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] addr_exp(input int k);
        logic [NS-1:0] v;
        for (int i = 0; i < NS; i++) v[i] = (i != k);
        return v;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One request; checks frames, reply and busy handshake.
    task automatic txn(input int k, input logic [DW-1:0] data,
                       input logic [DW-1:0] reply, input bit want_addr);
        int a0 = a_frames, d0 = d_frames, w = 0;
        s_reply = reply;
        @(negedge clk);
        req_valid = 1'b1; req_slave = 3'(k); req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 busy after accept", busy, 1'b1);
        while (!done && w < 2000) begin @(negedge clk); w++; end
        check("R7 reply captured", rx_data, reply);
        check("R10 busy low at done", busy, 1'b0);
        check(want_addr ? "R5 address frame sent" : "R4 address frame skipped",
              a_frames - a0, want_addr ? 1 : 0);
        if (want_addr) begin
            check("R3 address pattern", a_val, addr_exp(k));
            check("R3 address bit count", a_bits, NS);
        end
        check("R6 data frame count", d_frames - d0, 1);
        check("R6 data value", d_val, data);
        check("R8 data rising edges", d_bits, DW);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 sel_addr_n", sel_addr_n, 1'b1);
        check("R1 sel_data_n", sel_data_n, 1'b1);
        do_reset();
        check("R1 sclk", sclk, 1'b0);
        check("R1 busy", busy, 1'b0);
        check("R1 done", done, 1'b0);
    endtask

    task automatic t_first_and_repeat();
        txn(3, 8'hA5, 8'h3C, 1'b1);   // R2 first request addresses
        txn(3, 8'h5A, 8'hC3, 1'b0);   // R4 same slave skips
        txn(3, 8'h00, 8'hFF, 1'b0);
    endtask

    task automatic t_switch();
        txn(0, 8'hFF, 8'h00, 1'b1);   // R5 edge slave 0
        txn(7, 8'h81, 8'h7E, 1'b1);   // R5 edge slave 7
        txn(0, 8'h12, 8'h34, 1'b1);
    endtask

    task automatic t_ignore_busy();
        int d0 = d_frames, a0 = a_frames, w = 0;
        s_reply = 8'h99;
        @(negedge clk);
        req_valid = 1'b1; req_slave = 3'd5; req_data = 8'h66;
        @(negedge clk);
        req_slave = 3'd2; req_data = 8'h11;   // held while busy: ignored
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        while (!done && w < 2000) begin @(negedge clk); w++; end
        check("R10 first request reply", rx_data, 8'h99);
        check("R10 first request data", d_val, 8'h66);
        repeat (60) @(negedge clk);
        check("R10 ignored request no frame", d_frames - d0, 1);
        check("R10 ignored request no addr", a_frames - a0, 1);
        txn(5, 8'h77, 8'h88, 1'b0);   // cache still holds slave 5
    endtask

    task automatic t_reset_invalidates();
        do_reset();
        txn(5, 8'h3E, 8'hE3, 1'b1);   // R2 address again after reset
    endtask

    task automatic t_monitor();
        check("R8 sclk idle low", v_idle, 0);
        check("R6 selects exclusive", v_both, 0);
        check("R9 inter-frame gap", v_gap, 0);
        check("R10 done one cycle", v_done, 0);
    endtask

    initial begin
        t_reset_state();
        t_first_and_repeat();
        t_switch();
        t_ignore_busy();
        t_reset_invalidates();
        t_monitor();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule